// File: doc/BRIEF.md
# Ping-Pong Buffered Peripheral DMA Channel

This block is one peripheral DMA channel with two buffer slots, A and B. Each slot has its own start address and byte count. The channel drains the slot chosen by its buffer-select flag. When that slot's count runs out, the channel moves to the other slot. Software can therefore refill the idle slot while the busy one is still moving data. A peripheral asks for data one burst at a time over a request/acknowledge pair. The channel turns each request into one access on a simple memory port: the address, the burst length in bytes, and the direction.

Software uses a small word-indexed register port. The byte offset of a register is four times its index. Index 0 is the device configuration word. Indices 1, 2 and 3 give three views of the control/status byte: write-one-to-set, write-one-to-clear and read. Indices 4 to 7 hold slot A start, slot A count, slot B start and slot B count. The slot registers are the live transfer state, so reading the active slot gives the residue directly. A level interrupt reports completion and errors.

Top module: `pingpong_dma_chan`

## Requirements
- R1: After reset, the control/status byte reads 0, `irq` is low and `mem_req` is low.
- R2: The control/status byte has these bits: 0 run, 1 interrupt enable, 2 error, 3 slot A done, 4 slot A start, 5 slot B done, 6 slot B start, 7 buffer select (0 is A, 1 is B). A one written at index 1 sets the matching bit. A one written at index 2 clears it. Zero bits have no effect at either index. Bit 7 cannot be written.
- R3: Index 3 returns the control/status byte. Index 0 returns the configuration word as it was written.
- R4: A slot start address always reads back with bits 1:0 equal to zero. A slot count keeps only its low 13 bits, so its maximum value is 0x1fff.
- R5: One burst is 4 bytes, or 8 bytes when configuration bit 2 is 1. The burst is doubled when configuration bit 3 is 1. Each acknowledged memory access advances the slot address by one burst. It lowers the count by one burst, saturating at zero. `mem_bytes` shows the burst size.
- R6: When the active slot's count reaches zero, three things happen: its start bit clears, its done bit sets, and the buffer select toggles.
- R7: If the other slot's start bit is already set, its first memory request rises in the second clock edge after the completing acknowledge. There is no idle beat between the slots.
- R8: A started slot whose count is 0 completes at once and issues no memory request.
- R9: `irq` is high exactly when interrupt enable is 1 and at least one of error, done A or done B is 1.
- R10: Clearing run lets a burst already in flight finish and then issues no new request. Setting run again resumes from the live address and count.
- R11: An error response on the memory port sets the error bit and clears run. It leaves the slot address, count and start bit unchanged.
- R12: Reading a slot's start or count register returns its live current address and remaining count.
- R13: `mem_we` is 1 when configuration bit 0 is 1 (device to memory) and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_we | input | 1 | Register write strobe |
| host_addr | input | 3 | Register word index |
| host_wdata | input | 32 | Register write data |
| host_rdata | output | 32 | Register read data, combinational |
| mem_req | output | 1 | Memory access request, held until ack or error |
| mem_we | output | 1 | Memory access is a write (device to memory) |
| mem_addr | output | 32 | Memory access address |
| mem_bytes | output | 5 | Bytes in this access |
| mem_ack | input | 1 | Memory access done |
| mem_err | input | 1 | Memory access failed |
| per_req | input | 1 | Peripheral asks for one burst |
| per_ack | output | 1 | Burst served, one-cycle pulse |
| irq | output | 1 | Interrupt request |

## Verification
A register write takes effect at the clock edge that samples the strobe. The read port is combinational, so the new value can be checked half a cycle later. A memory request rises one edge after run, start, a non-zero count and a peripheral request are all seen together. The acknowledge is consumed at the next edge, and that same edge updates the slot and any completion flags. The bench drives inputs and samples outputs a short delay after the falling edge. It logs the cycle of every request rise and every acknowledge, so the slot hand-over gap can be checked as exactly two cycles. Checks on pause and on errors wait several idle cycles first, then confirm that the request count and the live slot values no longer move.

// File: rtl/pingpong_dma_chan.sv
module pingpong_dma_chan #(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int CW = 13
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_we,
  input  logic [2:0]    host_addr,
  input  logic [DW-1:0] host_wdata,
  output logic [DW-1:0] host_rdata,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [4:0]    mem_bytes,
  input  logic          mem_ack,
  input  logic          mem_err,
  input  logic          per_req,
  output logic          per_ack,
  output logic          irq
);

  localparam logic [2:0] IX_CFG = 3'd0, IX_SET = 3'd1, IX_CLR = 3'd2, IX_STAT = 3'd3;
  localparam logic [2:0] IX_SA = 3'd4, IX_CA = 3'd5, IX_SB = 3'd6, IX_CB = 3'd7;

  logic [DW-1:0] cfg;
  logic          run, ie, err_f, biu, busy;
  logic [1:0]    done, strt;
  logic [AW-1:0] s_addr [2];
  logic [CW-1:0] s_cnt  [2];

  logic          act;
  logic [CW-1:0] act_cnt, new_cnt, burst_c;
  logic [4:0]    burst;
  logic [7:0]    stat, ws, wc;
  logic          go, zero_done, issue, beat_ok, beat_err, finish;

  assign act       = biu;
  assign act_cnt   = s_cnt[act];
  assign burst     = 5'd4 << (2'(cfg[2]) + 2'(cfg[3]));
  assign burst_c   = CW'(burst);
  assign new_cnt   = (act_cnt > burst_c) ? act_cnt - burst_c : '0;
  assign go        = run && strt[act] && !busy;
  assign zero_done = go && (act_cnt == '0);
  assign issue     = go && (act_cnt != '0) && per_req;
  assign beat_ok   = busy && mem_ack;
  assign beat_err  = busy && mem_err && !mem_ack;
  assign finish    = zero_done || (beat_ok && new_cnt == '0);

  assign stat = {biu, strt[1], done[1], strt[0], done[0], err_f, ie, run};
  assign ws   = (host_we && host_addr == IX_SET) ? host_wdata[7:0] : 8'h00;
  assign wc   = (host_we && host_addr == IX_CLR) ? host_wdata[7:0] : 8'h00;

  assign mem_req   = busy;
  assign mem_we    = cfg[0];
  assign mem_bytes = burst;
  assign per_ack   = beat_ok;
  assign irq       = ie && (err_f || done[0] || done[1]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg <= '0;
    end else if (host_we && host_addr == IX_CFG) begin
      cfg <= host_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run   <= 1'b0;
      ie    <= 1'b0;
      err_f <= 1'b0;
      done  <= '0;
      strt  <= '0;
      biu   <= 1'b0;
    end else begin
      if (beat_err)   run <= 1'b0;
      else if (ws[0]) run <= 1'b1;
      else if (wc[0]) run <= 1'b0;

      if (ws[1])      ie <= 1'b1;
      else if (wc[1]) ie <= 1'b0;

      if (beat_err)   err_f <= 1'b1;
      else if (ws[2]) err_f <= 1'b1;
      else if (wc[2]) err_f <= 1'b0;

      for (int i = 0; i < 2; i++) begin
        if (finish && act == 1'(i))  done[i] <= 1'b1;
        else if (ws[3 + 2*i])        done[i] <= 1'b1;
        else if (wc[3 + 2*i])        done[i] <= 1'b0;

        if (ws[4 + 2*i])             strt[i] <= 1'b1;
        else if (finish && act == 1'(i)) strt[i] <= 1'b0;
        else if (wc[4 + 2*i])        strt[i] <= 1'b0;
      end

      if (finish) biu <= ~biu;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 2; i++) begin
        s_addr[i] <= '0;
        s_cnt[i]  <= '0;
      end
    end else begin
      for (int i = 0; i < 2; i++) begin
        if (host_we && host_addr == IX_SA + 3'(2*i))
          s_addr[i] <= {host_wdata[AW-1:2], 2'b00};
        else if (beat_ok && act == 1'(i))
          s_addr[i] <= s_addr[i] + AW'(burst);

        if (host_we && host_addr == IX_CA + 3'(2*i))
          s_cnt[i] <= host_wdata[CW-1:0];
        else if (beat_ok && act == 1'(i))
          s_cnt[i] <= new_cnt;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      mem_addr <= '0;
    end else if (issue) begin
      busy     <= 1'b1;
      mem_addr <= s_addr[act];
    end else if (beat_ok || beat_err) begin
      busy     <= 1'b0;
    end
  end

  always_comb begin
    case (host_addr)
      IX_CFG:  host_rdata = cfg;
      IX_STAT: host_rdata = DW'(stat);
      IX_SA:   host_rdata = DW'(s_addr[0]);
      IX_CA:   host_rdata = DW'(s_cnt[0]);
      IX_SB:   host_rdata = DW'(s_addr[1]);
      IX_CB:   host_rdata = DW'(s_cnt[1]);
      default: host_rdata = '0;
    endcase
  end

  AST_REQ_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_req) |-> $past(run)); // R10

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack && !mem_err) |=> mem_req); // R5

  AST_ERR_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_err && !mem_ack) |=> (err_f && !run)); // R11

  AST_LAST_BEAT_SWITCH: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_ack && act_cnt <= burst_c) |=> (biu != $past(biu))); // R6

  AST_NO_EMPTY_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_req) |-> ($past(act_cnt) != '0)); // R8

endmodule

// File: tb/tb_pingpong_dma_chan.sv
module tb_pingpong_dma_chan;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_we = 1'b0;
  logic [2:0]  host_addr = 3'd0;
  logic [31:0] host_wdata = 32'd0;
  logic [31:0] host_rdata;
  logic        mem_req, mem_we, per_ack, irq;
  logic [31:0] mem_addr;
  logic [4:0]  mem_bytes;
  logic        mem_ack = 1'b0;
  logic        mem_err = 1'b0;
  logic        per_req = 1'b0;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int nreq = 0;
  int nack = 0;
  bit err_next = 1'b0;
  bit prev_req = 1'b0;
  bit finished = 1'b0;
  logic [31:0] log_addr [32];
  logic [4:0]  log_bytes [32];
  logic        log_we [32];
  int          rise_cyc [32];
  int          ack_cyc [32];

  pingpong_dma_chan dut (
    .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_bytes(mem_bytes),
    .mem_ack(mem_ack), .mem_err(mem_err), .per_req(per_req),
    .per_ack(per_ack), .irq(irq)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (mem_req && !prev_req) begin
      if (nreq < 32) begin
        log_addr[nreq]  = mem_addr;
        log_bytes[nreq] = mem_bytes;
        log_we[nreq]    = mem_we;
        rise_cyc[nreq]  = cyc;
      end
      nreq = nreq + 1;
    end
    prev_req = mem_req;
    if (mem_req && !mem_ack && !mem_err) begin
      if (err_next) begin
        mem_err  = 1'b1;
        err_next = 1'b0;
      end else begin
        mem_ack = 1'b1;
        if (nack < 32) ack_cyc[nack] = cyc;
        nack = nack + 1;
      end
    end else begin
      mem_ack = 1'b0;
      mem_err = 1'b0;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); #2;
    host_addr = a; host_wdata = d; host_we = 1'b1;
    @(negedge clk); #2;
    host_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] v);
    host_addr = a; #1;
    v = host_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
    #2;
  endtask

  task automatic wait_bit(input int b, input string tag);
    logic [31:0] v;
    int n = 0;
    do begin
      @(negedge clk); #2;
      rd(3'd3, v);
      n++;
    end while (!v[b] && n < 2000);
    chk(tag, {31'd0, v[b]}, 32'd1);
  endtask

  task automatic t_reset;
    logic [31:0] v;
    rd(3'd3, v);
    chk("R1 status after reset", v, 32'h0);
    chk("R1 irq after reset", {31'd0, irq}, 32'd0);
    chk("R1 mem_req after reset", {31'd0, mem_req}, 32'd0);
  endtask

  task automatic t_setclr;
    logic [31:0] v;
    wr(3'd1, 32'h02); rd(3'd3, v); chk("R2 set ie", v, 32'h02);
    wr(3'd1, 32'h00); rd(3'd3, v); chk("R2 set zero no effect", v, 32'h02);
    wr(3'd2, 32'h00); rd(3'd3, v); chk("R2 clear zero no effect", v, 32'h02);
    wr(3'd1, 32'h80); rd(3'd3, v); chk("R2 select bit not writable", v, 32'h02);
    wr(3'd2, 32'h02); rd(3'd3, v); chk("R2 clear ie", v, 32'h00);
  endtask

  task automatic t_regs;
    logic [31:0] v;
    wr(3'd0, 32'hA5); rd(3'd0, v); chk("R3 config readback", v, 32'hA5);
    wr(3'd0, 32'h0);
    wr(3'd4, 32'h12345677); rd(3'd4, v); chk("R4 start low bits dropped", v, 32'h12345674);
    wr(3'd5, 32'hFFFF); rd(3'd5, v); chk("R4 count masked", v, 32'h1FFF);
  endtask

  task automatic t_pingpong;
    logic [31:0] v;
    int b0 = nack;
    int q0 = nreq;
    wr(3'd0, 32'h0);
    wr(3'd4, 32'h1000); wr(3'd5, 32'd10);
    wr(3'd6, 32'h2003); wr(3'd7, 32'd8);
    per_req = 1'b1;
    wr(3'd1, 32'h53);
    wait_bit(5, "R6 slot B done");
    chk("R5 beat count", nack - b0, 32'd5);
    chk("R5 beat0 addr", log_addr[q0],   32'h1000);
    chk("R5 beat1 addr", log_addr[q0+1], 32'h1004);
    chk("R5 beat2 addr", log_addr[q0+2], 32'h1008);
    chk("R7 slot B first addr", log_addr[q0+3], 32'h2000);
    chk("R5 burst bytes", {27'd0, log_bytes[q0]}, 32'd4);
    chk("R13 read direction", {31'd0, log_we[q0]}, 32'd0);
    chk("R7 no gap at switch", rise_cyc[q0+3] - ack_cyc[b0+2], 32'd2);
    rd(3'd3, v); chk("R6 status after both", v, 32'h2B);
    rd(3'd4, v); chk("R12 A addr", v, 32'h100C);
    rd(3'd5, v); chk("R5 A count saturates", v, 32'd0);
    rd(3'd6, v); chk("R12 B addr", v, 32'h2008);
    chk("R9 irq on done", {31'd0, irq}, 32'd1);
    wr(3'd2, 32'h28);
    chk("R9 irq after ack", {31'd0, irq}, 32'd0);
  endtask

  task automatic t_wide;
    logic [31:0] v;
    int b0 = nack;
    int q0 = nreq;
    wr(3'd0, 32'h0D);
    wr(3'd4, 32'h3000); wr(3'd5, 32'd20);
    wr(3'd1, 32'h10);
    wait_bit(3, "R6 slot A done wide");
    chk("R5 wide beats", nack - b0, 32'd2);
    chk("R5 wide bytes", {27'd0, log_bytes[q0]}, 32'd16);
    chk("R13 write direction", {31'd0, log_we[q0]}, 32'd1);
    rd(3'd4, v); chk("R5 wide end addr", v, 32'h3020);
    rd(3'd3, v); chk("R6 select now B", v, 32'h8B);
    wr(3'd2, 32'h08);
    wr(3'd0, 32'h0);
  endtask

  task automatic t_zero;
    logic [31:0] v;
    int q0 = nreq;
    wr(3'd7, 32'd0);
    wr(3'd1, 32'h40);
    idle(3);
    rd(3'd3, v); chk("R8 zero count completes", v, 32'h23);
    chk("R8 no request", nreq - q0, 32'd0);
    wr(3'd2, 32'h20);
  endtask

  task automatic t_pause;
    logic [31:0] v;
    int b0 = nack;
    int n, q1, k;
    wr(3'd4, 32'h4000); wr(3'd5, 32'd40);
    wr(3'd1, 32'h10);
    k = 0;
    while (nack - b0 < 3 && k < 500) begin @(negedge clk); #2; k++; end
    wr(3'd2, 32'h01);
    idle(5);
    n = nack - b0;
    q1 = nreq;
    idle(10);
    chk("R10 no request while stopped", nreq - q1, 32'd0);
    rd(3'd4, v); chk("R12 live addr paused", v, 32'h4000 + 4*n);
    rd(3'd5, v); chk("R12 live count paused", v, 40 - 4*n);
    wr(3'd1, 32'h01);
    wait_bit(3, "R10 resume completes");
    chk("R10 resume addr", log_addr[q1], 32'h4000 + 4*n);
    chk("R10 total beats", nack - b0, 32'd10);
    rd(3'd4, v); chk("R10 final addr", v, 32'h4028);
    wr(3'd2, 32'h08);
  endtask

  task automatic t_error;
    logic [31:0] v;
    int b0 = nack;
    wr(3'd6, 32'h5000); wr(3'd7, 32'd12);
    err_next = 1'b1;
    wr(3'd1, 32'h40);
    wait_bit(2, "R11 error flagged");
    idle(4);
    rd(3'd3, v); chk("R11 run cleared, start kept", v, 32'hC6);
    rd(3'd6, v); chk("R11 addr unchanged", v, 32'h5000);
    rd(3'd7, v); chk("R11 count unchanged", v, 32'd12);
    chk("R11 no ack", nack - b0, 32'd0);
    chk("R9 irq on error", {31'd0, irq}, 32'd1);
    wr(3'd2, 32'h44);
  endtask

  task automatic t_irq;
    logic [31:0] v;
    wr(3'd2, 32'h02);
    wr(3'd1, 32'h08);
    chk("R9 irq masked", {31'd0, irq}, 32'd0);
    wr(3'd1, 32'h02);
    chk("R9 irq enabled", {31'd0, irq}, 32'd1);
    wr(3'd2, 32'h08);
    chk("R9 irq cleared", {31'd0, irq}, 32'd0);
    rd(3'd3, v); chk("R2 final status", v, 32'h82);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #2;
    t_reset;
    rst_n = 1'b1;
    idle(2);
    t_reset;
    t_setclr;
    t_regs;
    t_pingpong;
    t_wide;
    t_zero;
    t_pause;
    t_error;
    t_irq;
    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule